// File: doc/BRIEF.md
# Dual-Channel Host Window Decoder

This block sits between a 20-bit memory-mapped host bus and two identical channel controllers on one expansion card. It checks each bus cycle against a 512-byte block placed by ten static configuration inputs in the upper half of the address space. When a read or write falls inside that block, it selects one of two 256-byte channel register windows and passes the low address byte on as the channel-local register address. The first window starts at the block base and the second starts 100h above it.

The block also routes each channel's interrupt request onto a 16-line host interrupt vector. A 4-bit selection code per channel picks the line. Only some line numbers are legal targets, and any other code silences that channel. Two channels routed to the same line share it as a wired OR.

All outputs are registered. They follow the inputs sampled at the previous rising clock edge.

Top module: `dual_chan_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `ch0_cs`, `ch1_cs`, `ch_addr` and `irq_lines` are all zero.
- R2: No chip select is asserted for a cycle whose `bus_addr[19]` is 0.
- R3: A cycle hits the card only when `bus_addr[18:9]` equals `base_cfg[9:0]` bit for bit. So `base_cfg` = 0 places the block at 080000h, and 3FFh places it at 0FFE00h.
- R4: On a hit, `bus_addr[8]` = 0 asserts `ch0_cs` and `bus_addr[8]` = 1 asserts `ch1_cs`.
- R5: `ch_addr` carries `bus_addr[7:0]` while a select is asserted and is zero otherwise.
- R6: With both `rd_en` and `wr_en` low, no chip select is asserted.
- R7: At most one of `ch0_cs` and `ch1_cs` is high in any cycle.
- R8: A channel whose request is high and whose 4-bit code is one of 3, 4, 5, 6, 7, 10, 11, 12, 14 or 15 drives `irq_lines[code]` high. A channel whose request is low drives no line.
- R9: Codes 0, 1, 2, 8, 9 and 13 drive no interrupt line.
- R10: When both channels select the same legal line, that line is the OR of the two requests.
- R11: Each output reflects the inputs present at the preceding rising edge of `clk`. The output latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Host memory address |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| base_cfg | input | 10 | Static block-base setting, compared with address bits 18..9 |
| ch0_irq_sel | input | 4 | Interrupt line code for channel 0 |
| ch1_irq_sel | input | 4 | Interrupt line code for channel 1 |
| ch0_irq_req | input | 1 | Interrupt request from channel 0 |
| ch1_irq_req | input | 1 | Interrupt request from channel 1 |
| ch0_cs | output | 1 | Channel 0 window select |
| ch1_cs | output | 1 | Channel 1 window select |
| ch_addr | output | 8 | Channel-local register address |
| irq_lines | output | 16 | Host interrupt lines, bit n is line n |

## Verification
The bench builds the block with its default parameters: a 20-bit address, 256-byte windows (so the block base has 512-byte granularity), 16 interrupt lines and the legal-line mask that marks lines 3–7, 10–12, 14 and 15. With these values it can sweep all sixteen selection codes for both channels. It can also place the block at the lowest and highest bases and reach the last byte of each window. Directed cases cover a clear A19, a base off by one block, idle strobes and a shared line. A pseudo-random stream of addresses near the base then exercises hits and misses together.

// File: rtl/dual_chan_decoder_pkg.sv
package dual_chan_decoder_pkg;
    localparam int ADDR_W    = 20;
    localparam int LOC_W     = 8;
    localparam int NUM_CH    = 2;
    localparam int SEL_W     = 4;
    localparam int NUM_LINES = 1 << SEL_W;
    localparam int CFG_W     = ADDR_W - LOC_W - 2;
    localparam logic [NUM_LINES-1:0] LEGAL_LINES = 16'b1101_1100_1111_1000;

    typedef struct packed {
        logic [NUM_CH-1:0]    cs;
        logic [LOC_W-1:0]     loc;
        logic [NUM_LINES-1:0] irq;
    } dec_state_t;
endpackage

// File: rtl/chan_window_decode.sv
module chan_window_decode #(
    parameter int ADDR_W = 20,
    parameter int LOC_W  = 8,
    parameter int NUM_CH = 2,
    localparam int CFG_W = ADDR_W - LOC_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  base_cfg,
    input  logic              access,
    output logic [NUM_CH-1:0] cs,
    output logic [LOC_W-1:0]  loc
);
    logic blk_hit;

    // Top address bit must be high; the next CFG_W bits must equal the setting.
    assign blk_hit = access && addr[ADDR_W-1] && (addr[ADDR_W-2:LOC_W+1] == base_cfg);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
        assign cs[ch] = blk_hit && (addr[LOC_W] == ch[0]);
    end

    assign loc = blk_hit ? addr[LOC_W-1:0] : '0;
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
    parameter int SEL_W = 4,
    parameter int NUM_LINES = 1 << SEL_W,
    parameter logic [NUM_LINES-1:0] LEGAL_MASK = '1
) (
    input  logic [SEL_W-1:0]     sel0,
    input  logic [SEL_W-1:0]     sel1,
    input  logic                 req0,
    input  logic                 req1,
    output logic [NUM_LINES-1:0] lines
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (LEGAL_MASK[i]) begin : g_legal
            assign lines[i] = (req0 && (sel0 == SEL_W'(i))) ||
                              (req1 && (sel1 == SEL_W'(i)));
        end else begin : g_tied
            assign lines[i] = 1'b0;
        end
    end
endmodule

// File: rtl/dual_chan_decoder.sv
module dual_chan_decoder
    import dual_chan_decoder_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [CFG_W-1:0]     base_cfg,
    input  logic [SEL_W-1:0]     ch0_irq_sel,
    input  logic [SEL_W-1:0]     ch1_irq_sel,
    input  logic                 ch0_irq_req,
    input  logic                 ch1_irq_req,
    output logic                 ch0_cs,
    output logic                 ch1_cs,
    output logic [LOC_W-1:0]     ch_addr,
    output logic [NUM_LINES-1:0] irq_lines
);
    logic [NUM_CH-1:0]    cs_w;
    logic [LOC_W-1:0]     loc_w;
    logic [NUM_LINES-1:0] irq_w;
    dec_state_t           st_d, st_q;

    chan_window_decode #(
        .ADDR_W (ADDR_W),
        .LOC_W  (LOC_W),
        .NUM_CH (NUM_CH)
    ) win_i (
        .addr     (bus_addr),
        .base_cfg (base_cfg),
        .access   (rd_en || wr_en),
        .cs       (cs_w),
        .loc      (loc_w)
    );

    irq_line_router #(
        .SEL_W      (SEL_W),
        .NUM_LINES  (NUM_LINES),
        .LEGAL_MASK (LEGAL_LINES)
    ) irq_i (
        .sel0  (ch0_irq_sel),
        .sel1  (ch1_irq_sel),
        .req0  (ch0_irq_req),
        .req1  (ch1_irq_req),
        .lines (irq_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cs  = cs_w;
        st_d.loc = loc_w;
        st_d.irq = irq_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch0_cs    = st_q.cs[0];
    assign ch1_cs    = st_q.cs[1];
    assign ch_addr   = st_q.loc;
    assign irq_lines = st_q.irq;

    a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.cs));

    a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en || wr_en) |-> (st_q.cs == '0));

    a_r2_top_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_addr[ADDR_W-1]) |-> (st_q.cs == '0));

    a_r5_idle_loc: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cs == '0) |-> (st_q.loc == '0));

    a_r9_illegal_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (!LEGAL_LINES[$past(ch0_irq_sel)] && !LEGAL_LINES[$past(ch1_irq_sel)])
            |-> (st_q.irq == '0));

    a_r8_at_most_two: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.irq) <= 2);
endmodule

// File: tb/dual_chan_decoder_tb_top.sv
module dual_chan_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  base_cfg = '0;
    logic [3:0]  ch0_irq_sel = '0;
    logic [3:0]  ch1_irq_sel = '0;
    logic        ch0_irq_req = 1'b0;
    logic        ch1_irq_req = 1'b0;
    logic        ch0_cs, ch1_cs;
    logic [7:0]  ch_addr;
    logic [15:0] irq_lines;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  cs;
        logic [7:0]  loc;
        logic [15:0] irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    dual_chan_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en),
        .base_cfg(base_cfg), .ch0_irq_sel(ch0_irq_sel), .ch1_irq_sel(ch1_irq_sel),
        .ch0_irq_req(ch0_irq_req), .ch1_irq_req(ch1_irq_req),
        .ch0_cs(ch0_cs), .ch1_cs(ch1_cs), .ch_addr(ch_addr), .irq_lines(irq_lines)
    );

    function automatic bit legal_code(input logic [3:0] c);
        case (c)
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11, 4'd12, 4'd14, 4'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Reference model built from the requirements.
    task automatic drive(input logic [19:0] a, input logic rd, input logic wr,
                         input logic [9:0] base, input logic [3:0] s0, input logic [3:0] s1,
                         input logic r0, input logic r1, input string tag);
        exp_t e;
        logic hit;
        @(negedge clk);
        bus_addr = a; rd_en = rd; wr_en = wr; base_cfg = base;
        ch0_irq_sel = s0; ch1_irq_sel = s1; ch0_irq_req = r0; ch1_irq_req = r1;
        hit   = (rd || wr) && a[19] && (a[18:9] == base);
        e.cs  = {hit && a[8], hit && !a[8]};
        e.loc = hit ? a[7:0] : 8'h00;
        e.irq = '0;
        if (r0 && legal_code(s0)) e.irq[s0] = 1'b1;
        if (r1 && legal_code(s1)) e.irq[s1] = 1'b1;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic compare(input string tag, input logic [25:0] act, input logic [25:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual cs=%b addr=%h irq=%h expected cs=%b addr=%h irq=%h",
                     tag, act[25:24], act[23:16], act[15:0], exp[25:24], exp[23:16], exp[15:0]);
        end
    endtask

    // Monitor: one result per rising edge, sampled after the edge settles.
    initial begin
        wait (rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                compare(e.tag, {ch1_cs, ch0_cs, ch_addr, irq_lines}, {e.cs, e.loc, e.irq});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        localparam logic [9:0] B = 10'h240;   // block at 0C8000h
        // R1: hitting inputs presented during reset must not show.
        bus_addr = 20'hC8012; rd_en = 1'b1; base_cfg = B;
        ch0_irq_sel = 4'd5; ch0_irq_req = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset", {ch1_cs, ch0_cs, ch_addr, irq_lines}, 26'h0);
        @(negedge clk);
        rst_n = 1'b1;
        bus_addr = 20'h0; rd_en = 1'b0; ch0_irq_req = 1'b0;

        drive(20'hC8012, 1, 0, B, 0, 0, 0, 0, "R4 R5 ch0 read");
        drive(20'hC8112, 1, 0, B, 0, 0, 0, 0, "R4 R5 ch1 read");
        drive(20'hC81FF, 0, 1, B, 0, 0, 0, 0, "R4 R5 ch1 write top byte");
        drive(20'hC80FF, 1, 1, B, 0, 0, 0, 0, "R4 R7 ch0 both strobes");
        drive(20'hC8044, 0, 0, B, 0, 0, 0, 0, "R6 no strobe");
        drive(20'h48012, 1, 0, B, 0, 0, 0, 0, "R2 top bit low");
        drive(20'hC8212, 1, 0, B, 0, 0, 0, 0, "R3 next block");
        drive(20'hC7E12, 1, 0, B, 0, 0, 0, 0, "R3 previous block");
        drive(20'h80005, 1, 0, 10'h000, 0, 0, 0, 0, "R3 lowest base");
        drive(20'hFFF80, 0, 1, 10'h3FF, 0, 0, 0, 0, "R3 highest base");
        drive(20'hC8033, 1, 0, B, 0, 0, 0, 0, "R11 step a");
        drive(20'hC8134, 1, 0, B, 0, 0, 0, 0, "R11 step b");
        drive(20'hC8035, 0, 0, B, 0, 0, 0, 0, "R11 step c");

        for (int c = 0; c < 16; c++)
            drive(20'h0, 0, 0, B, 4'(c), 4'd0, 1, 0,
                  legal_code(4'(c)) ? "R8 ch0 code sweep" : "R9 ch0 illegal code");
        for (int c = 0; c < 16; c++)
            drive(20'h0, 0, 0, B, 4'd0, 4'(c), 0, 1,
                  legal_code(4'(c)) ? "R8 ch1 code sweep" : "R9 ch1 illegal code");
        drive(20'h0, 0, 0, B, 4'd7, 4'd10, 0, 0, "R8 requests low");
        drive(20'h0, 0, 0, B, 4'd5, 4'd5, 1, 0, "R10 shared ch0 only");
        drive(20'h0, 0, 0, B, 4'd5, 4'd5, 0, 1, "R10 shared ch1 only");
        drive(20'h0, 0, 0, B, 4'd5, 4'd5, 1, 1, "R10 shared both");
        drive(20'h0, 0, 0, B, 4'd14, 4'd3, 1, 1, "R8 two lines");

        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            a = {1'b1, B, 9'h0} + 20'($urandom_range(0, 1535)) - 20'd512;
            if ($urandom_range(0, 7) == 0) a[19] = 1'b0;
            drive(a, 1'($urandom), 1'($urandom), B, 4'($urandom), 4'($urandom),
                  1'($urandom), 1'($urandom), "R7 R11 random mix");
        end

        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule